// File: doc/BRIEF.md
# Port Activity Status Formatter

This block prepares the per-port status fields that a serial LED chain later shifts out. It serves up to eight network ports. For each port it takes two raw activity strobes, one for transmit and one for receive, plus a 6-bit status word written by software. Transmit activity means the port is sending packet data or carrier extension. Receive activity means the port has seen a non-idle cycle.

Each strobe is stretched so that even a single-cycle burst lights its indicator for a whole blink period. The blink period is an 8-bit count of latch ticks. A shared 4-bit format code then chooses which activity bits and how many status bits make up each port's field.

The block presents each port's field as a 6-bit vector and a 3-bit length. The bit that is shifted first sits at index 0. A registered copy of the port-enable mask goes out with the fields. Serialisation, LED clock generation and register access belong to neighbouring blocks.

Top module: `port_status_formatter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `field_dat`, `field_len` and `en_mask` are all zero, whatever the other inputs are.
- R2: Format codes 0, 1, 2 and 3 give a field of only status bits: the lowest 1, 2, 4 or 6 bits of the port's status, status bit 0 at field index 0. The length is 1, 2, 4 or 6.
- R3: Format codes 4, 5 and 6 put one merged activity bit at index 0, which is (TX lit OR RX lit). The lowest 1, 2 or 4 status bits follow from index 1 upward. The length is 2, 3 or 5.
- R4: Format codes 8, 9 and 10 put TX lit at index 0 and RX lit at index 1. The lowest 1, 2 or 4 status bits follow from index 2 upward. The length is 3, 4 or 6.
- R5: Format codes 7 and 11 to 15 give length 0 and an all-zero field for every port.
- R6: A port whose bit in `port_en_in` is 0 gives length 0 and an all-zero field. `en_mask` equals `port_en_in` delayed by one clock. Bit i of the mask belongs to port i: bits 0 to 3 cover the first interface and bits 4 to 7 cover the second.
- R7: After a single activity strobe, its indicator stays lit through the first rate-1 latch ticks. The tick that makes rate ticks in total clears it.
- R8: A new strobe on a lit indicator reloads the full blink count. The count restarts from that strobe.
- R9: A blink rate of 0 is illegal and is treated as 1. One latch tick after a strobe clears the indicator.
- R10: Field bits at or above the port's length are always zero.
- R11: Fields and the mask are registered. A change on `fmt_code`, `port_en_in` or `sw_status` shows at the outputs one clock later. An activity strobe shows two clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_tick | input | 1 | One-cycle pulse per LED latch period |
| blink_rate | input | 8 | Blink period in latch ticks (0 treated as 1) |
| fmt_code | input | 4 | Field format code shared by all ports |
| port_en_in | input | 8 | Per-port enable, bit i for port i |
| tx_act | input | 8 | Raw transmit activity strobes, bit i for port i |
| rx_act | input | 8 | Raw receive activity strobes, bit i for port i |
| sw_status | input | 48 | Software status, 6 bits per port, port i at [6i+5:6i] |
| field_dat | output | 48 | Field bits, port i at [6i+5:6i], first-shifted bit lowest |
| field_len | output | 24 | Field length 0..6, port i at [3i+2:3i] |
| en_mask | output | 8 | Registered port-enable mask |

## Verification
The formatter is swept over all sixteen format codes under several port patterns. Across the patterns, TX alone, RX alone and both together are lit on different port subsets, so the merged and split activity formats give different answers. The status words are per port and non-symmetric, so a wrong bit order or a wrong status width changes the expected value. Enable masks that skip alternate ports and that block every port separate gating from formatting. Single-port timing runs count latch ticks up to the exact tick that clears the indicator. These runs cover a retrigger partway through a period and the zero-rate case.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int STAT_W = 6;
  localparam int LEN_W  = 3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_MERGED = 2'd1,
    ACT_SPLIT  = 2'd2
  } act_mode_e;

  typedef struct packed {
    logic      ok;
    act_mode_e act;
    logic [2:0] nstat;
  } fmt_dec_t;

  // Upper two code bits pick the activity layout, lower two the status width.
  function automatic fmt_dec_t decode_fmt(input logic [3:0] code);
    fmt_dec_t d;
    d.ok    = 1'b0;
    d.act   = ACT_NONE;
    d.nstat = 3'd0;
    case (code[1:0])
      2'd0:    d.nstat = 3'd1;
      2'd1:    d.nstat = 3'd2;
      2'd2:    d.nstat = 3'd4;
      default: d.nstat = 3'd6;
    endcase
    case (code[3:2])
      2'b00: d.ok = 1'b1;
      2'b01: begin d.ok = (code[1:0] != 2'd3); d.act = ACT_MERGED; end
      2'b10: begin d.ok = (code[1:0] != 2'd3); d.act = ACT_SPLIT;  end
      default: d.ok = 1'b0;
    endcase
    if (!d.ok) begin
      d.act   = ACT_NONE;
      d.nstat = 3'd0;
    end
    return d;
  endfunction
endpackage

// File: rtl/blink_timebase.sv
module blink_timebase #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_eff
);
  localparam logic [RATE_W-1:0] RATE_MIN = RATE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) rate_eff <= RATE_MIN;
    else     rate_eff <= (rate_in == '0) ? RATE_MIN : rate_in;
  end
endmodule

// File: rtl/activity_stretch.sv
module activity_stretch #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              lit
);
  logic [RATE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                       remain <= '0;
    else if (strobe)               remain <= rate;
    else if (tick && remain != '0) remain <= remain - RATE_W'(1);
  end

  assign lit = (remain != '0);
endmodule

// File: rtl/field_packer.sv
module field_packer
  import psf_pkg::*;
(
  input  fmt_dec_t           dec,
  input  logic               en,
  input  logic               tx_lit,
  input  logic               rx_lit,
  input  logic [STAT_W-1:0]  stat,
  output logic [STAT_W-1:0]  dat,
  output logic [LEN_W-1:0]   len
);
  logic [STAT_W:0]   keep;
  logic [STAT_W-1:0] sm;

  always_comb begin
    keep = ((STAT_W+1)'(1) << dec.nstat) - (STAT_W+1)'(1);
    sm   = stat & keep[STAT_W-1:0];
    dat  = '0;
    len  = '0;
    if (en && dec.ok) begin
      case (dec.act)
        ACT_MERGED: begin
          dat = {sm[STAT_W-2:0], tx_lit | rx_lit};
          len = dec.nstat + LEN_W'(1);
        end
        ACT_SPLIT: begin
          dat = {sm[STAT_W-3:0], rx_lit, tx_lit};
          len = dec.nstat + LEN_W'(2);
        end
        default: begin
          dat = sm;
          len = dec.nstat;
        end
      endcase
    end
  end
endmodule

// File: rtl/port_status_formatter.sv
module port_status_formatter
  import psf_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int RATE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          latch_tick,
  input  logic [RATE_W-1:0]             blink_rate,
  input  logic [3:0]                    fmt_code,
  input  logic [NUM_PORTS-1:0]          port_en_in,
  input  logic [NUM_PORTS-1:0]          tx_act,
  input  logic [NUM_PORTS-1:0]          rx_act,
  input  logic [NUM_PORTS*STAT_W-1:0]   sw_status,
  output logic [NUM_PORTS*STAT_W-1:0]   field_dat,
  output logic [NUM_PORTS*LEN_W-1:0]    field_len,
  output logic [NUM_PORTS-1:0]          en_mask
);
  logic [RATE_W-1:0]          rate_eff;
  logic [NUM_PORTS-1:0]       tx_lit, rx_lit;
  logic [NUM_PORTS*STAT_W-1:0] dat_c;
  logic [NUM_PORTS*LEN_W-1:0]  len_c;
  fmt_dec_t                   dec;

  assign dec = decode_fmt(fmt_code);

  blink_timebase #(.RATE_W(RATE_W)) u_tb (
    .clk(clk), .rst(rst), .rate_in(blink_rate), .rate_eff(rate_eff)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    activity_stretch #(.RATE_W(RATE_W)) u_tx (
      .clk(clk), .rst(rst), .strobe(tx_act[p]), .tick(latch_tick),
      .rate(rate_eff), .lit(tx_lit[p])
    );
    activity_stretch #(.RATE_W(RATE_W)) u_rx (
      .clk(clk), .rst(rst), .strobe(rx_act[p]), .tick(latch_tick),
      .rate(rate_eff), .lit(rx_lit[p])
    );
    field_packer u_pack (
      .dec(dec), .en(port_en_in[p]), .tx_lit(tx_lit[p]), .rx_lit(rx_lit[p]),
      .stat(sw_status[p*STAT_W +: STAT_W]),
      .dat(dat_c[p*STAT_W +: STAT_W]), .len(len_c[p*LEN_W +: LEN_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_dat <= '0;
      field_len <= '0;
      en_mask   <= '0;
    end else begin
      field_dat <= dat_c;
      field_len <= len_c;
      en_mask   <= port_en_in;
    end
  end
endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
  parameter int NP = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    fmt_code,
  input logic [NP-1:0] port_en_in,
  input logic [NP*6-1:0] field_dat,
  input logic [NP*3-1:0] field_len,
  input logic [NP-1:0] en_mask
);
  AST_MASK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> en_mask == $past(port_en_in)); // R6

  AST_BAD_CODE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(fmt_code) == 4'h7 || $past(fmt_code) > 4'hA))
      |-> (field_dat == '0 && field_len == '0)); // R5

  for (genvar i = 0; i < NP; i++) begin : g_chk
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
      field_len[i*3 +: 3] <= 3'd6); // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (field_dat[i*6 +: 6] >> field_len[i*3 +: 3]) == 6'd0); // R10

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(port_en_in[i]))
        |-> (field_len[i*3 +: 3] == 3'd0 && field_dat[i*6 +: 6] == 6'd0)); // R6
  end
endmodule

bind port_status_formatter psf_checker #(.NP(NUM_PORTS)) u_psf_chk (
  .clk(clk), .rst(rst), .fmt_code(fmt_code), .port_en_in(port_en_in),
  .field_dat(field_dat), .field_len(field_len), .en_mask(en_mask)
);

// File: tb/port_status_formatter_test.sv
module port_status_formatter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        latch_tick = 1'b0;
  logic [7:0]  blink_rate = 8'd0;
  logic [3:0]  fmt_code = 4'd0;
  logic [7:0]  port_en_in = 8'd0;
  logic [7:0]  tx_act = 8'd0;
  logic [7:0]  rx_act = 8'd0;
  logic [47:0] sw_status = 48'd0;
  logic [47:0] field_dat;
  logic [23:0] field_len;
  logic [7:0]  en_mask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  port_status_formatter uut (
    .clk(clk), .rst(rst), .latch_tick(latch_tick), .blink_rate(blink_rate),
    .fmt_code(fmt_code), .port_en_in(port_en_in), .tx_act(tx_act),
    .rx_act(rx_act), .sw_status(sw_status), .field_dat(field_dat),
    .field_len(field_len), .en_mask(en_mask)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int port, input logic [5:0] ed, input logic [2:0] el);
    logic [5:0] ad;
    logic [2:0] al;
    ad = field_dat[port*6 +: 6];
    al = field_len[port*3 +: 3];
    checks++;
    if (ad !== ed || al !== el) begin
      errors++;
      $display("FAIL %s port %0d: dat=%h len=%0d expected dat=%h len=%0d", req, port, ad, al, ed, el);
    end
  endtask

  task automatic chk_mask(input string req, input logic [7:0] exp_m);
    checks++;
    if (en_mask !== exp_m) begin
      errors++;
      $display("FAIL %s mask=%h expected %h", req, en_mask, exp_m);
    end
  endtask

  // Arithmetic model of one port's field.
  task automatic model(input logic [3:0] f, input logic en, input logic t, input logic r,
                       input logic [5:0] s, output logic [5:0] d, output logic [2:0] l);
    int ns, na, v, pre;
    ns = 0; na = 0;
    if (f <= 4'd10 && f != 4'd7) begin
      case (f % 4)
        0: ns = 1;
        1: ns = 2;
        2: ns = 4;
        default: ns = 6;
      endcase
      na = f / 4;
    end
    pre = (na == 2) ? (2 * r + t) : (na == 1) ? (t | r) : 0;
    v = ((s % (1 << ns)) << na) + pre;
    if (!en) begin v = 0; ns = 0; na = 0; end
    d = v[5:0];
    l = 3'(ns + na);
  endtask

  task automatic pulse(input logic [7:0] tm, input logic [7:0] rm);
    tx_act = tm; rx_act = rm;
    cyc(1);
    tx_act = '0; rx_act = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      latch_tick = 1'b1;
      cyc(1);
      latch_tick = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx_pat [6];
    logic [7:0] rx_pat [6];
    logic [7:0] en_pat [6];
    logic [5:0] ed;
    logic [2:0] el;
    tx_pat = '{8'h0F, 8'h33, 8'h00, 8'hFF, 8'h81, 8'h5A};
    rx_pat = '{8'h3C, 8'h55, 8'hF0, 8'h00, 8'h18, 8'hA5};
    en_pat = '{8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'h00, 8'h7E};

    // R1: reset holds outputs at zero despite active inputs
    port_en_in = 8'hFF; fmt_code = 4'd3; sw_status = {8{6'h2B}};
    cyc(3);
    for (int i = 0; i < 8; i++) chk("R1", i, 6'd0, 3'd0);
    chk_mask("R1", 8'h00);
    rst = 1'b0;
    #0;
    @(posedge clk); #1;
    // R11: one clock after reset release the inputs appear
    model(4'd3, 1'b1, 1'b0, 1'b0, 6'h2B, ed, el);
    chk("R11", 0, ed, el);
    chk_mask("R11", 8'hFF);

    blink_rate = 8'd20;
    cyc(2);
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 8; i++) sw_status[i*6 +: 6] = 6'((p * 7 + i * 13 + 5) % 64);
      port_en_in = en_pat[p];
      pulse(tx_pat[p], rx_pat[p]);
      // R11: strobe reaches outputs two clocks after being sampled
      fmt_code = 4'd8;
      cyc(1);
      model(4'd8, en_pat[p][0], tx_pat[p][0], rx_pat[p][0], sw_status[5:0], ed, el);
      chk("R11", 0, ed, el);
      chk_mask("R6", en_pat[p]);
      for (int f = 0; f < 16; f++) begin
        fmt_code = 4'(f);
        cyc(2);
        for (int i = 0; i < 8; i++) begin
          string req;
          if (!en_pat[p][i]) req = "R6";
          else if (f < 4) req = "R2";
          else if (f >= 4 && f <= 6) req = "R3";
          else if (f >= 8 && f <= 10) req = "R4";
          else req = "R5";
          // full 6-bit compare also covers R10 (bits above length are zero)
          model(4'(f), en_pat[p][i], tx_pat[p][i], rx_pat[p][i], sw_status[i*6 +: 6], ed, el);
          chk(req, i, ed, el);
        end
      end
      ticks(20);
      cyc(1);
    end

    // R7: exact blink length with rate 4
    port_en_in = 8'hFF; sw_status = '0; fmt_code = 4'd8;
    blink_rate = 8'd4;
    cyc(2);
    pulse(8'h01, 8'h02);
    ticks(3);
    cyc(1);
    chk("R7", 0, 6'b000001, 3'd3);
    chk("R7", 1, 6'b000010, 3'd3);
    ticks(1);
    cyc(1);
    chk("R7", 0, 6'b000000, 3'd3);
    chk("R7", 1, 6'b000000, 3'd3);

    // R8: retrigger reloads the count
    pulse(8'h01, 8'h00);
    ticks(2);
    pulse(8'h01, 8'h00);
    ticks(3);
    cyc(1);
    chk("R8", 0, 6'b000001, 3'd3);
    ticks(1);
    cyc(1);
    chk("R8", 0, 6'b000000, 3'd3);

    // R9: rate zero behaves as one tick
    blink_rate = 8'd0;
    cyc(2);
    pulse(8'h00, 8'h04);
    cyc(1);
    chk("R9", 2, 6'b000010, 3'd3);
    ticks(1);
    cyc(1);
    chk("R9", 2, 6'b000000, 3'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule